// File: doc/BRIEF.md
# Serial ADC Conversion Frame Controller

This block sits on the host side of a four-wire serial link to a 12-bit, 8-input successive-approximation converter. A single-cycle start request, together with a channel number and mode settings, causes it to build an 8-bit command word, pull chip select low and run one fixed 24-clock frame. During the frame it shifts the command out, keeps the serial clock running while the converter resolves, and assembles the 12 returned result bits into a parallel word.

When the frame is over, chip select goes high. The result is then presented with a one-cycle valid strobe. A busy flag stays set until chip select has also been high for one full serial-clock period, and start requests that arrive while it is set are dropped. The serial clock is derived from the system clock by an even divide ratio. The command word always selects the converter's externally clocked conversion mode.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, cs_n=1, sclk=0, din=0, busy=0, result_valid=0 and result=0.
- R2: The command word is sent MSB first. Its bit 7 is 1. Bits 6:4 are the channel. Bit 3 is 1 for unipolar and 0 for bipolar. Bit 2 is 1 for single-ended and 0 for differential. Bit 1 is 1, which selects the external clock. Bit 0 equals pwr_down.
- R3: A start accepted while idle drives cs_n low on the next edge. The frame then has exactly 24 sclk periods of CLK_DIV system cycles each. sclk is low for the first half of each period, high for the second half, and low whenever cs_n is high.
- R4: din is set to command bit 7 when cs_n falls and changes only at sclk falling edges after that. It never changes while sclk is high, and it is 0 once the command has been sent and while cs_n is high.
- R5: dout is sampled at sclk rising edges. The samples at rising edges 10 through 21 of the frame form result[11] down to result[0], MSB first.
- R6: dout values at rising edges 1 to 9 and 22 to 24 of the frame have no effect on result.
- R7: cs_n returns high at the sclk falling edge that ends period 24, which is 24*CLK_DIV cycles after it fell. result_valid is high for exactly the one cycle after that. result does not change between frames.
- R8: busy is high from the accepting edge until CLK_DIV cycles after cs_n rises. A start request seen while busy is ignored.
- R9: Between two frames, cs_n stays high for at least CLK_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, sampled while idle |
| chan | input | CHAN_W | Input channel number |
| bipolar | input | 1 | 1 requests bipolar coding |
| differential | input | 1 | 1 requests differential input |
| pwr_down | input | 1 | Power-down request after conversion |
| busy | output | 1 | Frame or chip-select recovery in progress |
| cs_n | output | 1 | Chip select to converter, active low |
| sclk | output | 1 | Serial clock to converter |
| din | output | 1 | Serial command data to converter |
| dout | input | 1 | Serial result data from converter |
| result | output | RES_W | Last assembled conversion code |
| result_valid | output | 1 | One-cycle strobe when result is updated |

## Verification
Several properties are checked on every cycle: sclk and din stay low while chip select is high, din holds steady while sclk is high, result_valid lasts one cycle and only with chip select high, result is frozen during a frame, and chip select falls only from an idle state after its minimum high time. Other behaviour can only be shown by the bench's scenarios. That includes the exact command-word layout, which rising edges feed the result, whether padding and pre-result bits are ignored, and cycle-exact frame length. The bench checks these with a behavioural converter model and a per-cycle timing model, covering different channels, both coding modes, extreme codes, starts that arrive while busy, and back-to-back requests.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FRAME = 2'd1,
      SEQ_GAP   = 2'd2
   } seq_state_e;

   // width helper that never returns zero
   function automatic int unsigned width_of(input int unsigned count);
      return (count > 2) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/adcf_sclk_gen.sv
module adcf_sclk_gen #(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_evt,
   output logic fall_evt
);
   localparam int unsigned HALF = CLK_DIV / 2;
   localparam int unsigned PH_W = adcf_pkg::width_of(CLK_DIV);
   localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("adcf_sclk_gen: CLK_DIV must be even and at least 2");
      end
   endgenerate

   logic [PH_W-1:0] phase;

   assign rise_evt = run && (phase == PH_RISE);
   assign fall_evt = run && (phase == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         sclk  <= 1'b0;
      end else if (!run) begin
         phase <= '0;
         sclk  <= 1'b0;
      end else begin
         if (fall_evt) phase <= '0;
         else          phase <= phase + 1'b1;
         if (rise_evt)      sclk <= 1'b1;
         else if (fall_evt) sclk <= 1'b0;
      end
   end

   AST_SCLK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sclk); // R3

endmodule

// File: rtl/adcf_seq.sv
module adcf_seq #(
   parameter int unsigned CLK_DIV     = 4,
   parameter int unsigned FRAME_SCLKS = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fall_evt,
   output logic busy,
   output logic run,
   output logic cs_n,
   output logic accept,
   output logic done,
   output logic [adcf_pkg::width_of(FRAME_SCLKS)-1:0] period
);
   import adcf_pkg::*;

   localparam int unsigned PER_W = width_of(FRAME_SCLKS);
   localparam int unsigned GAP_W = width_of(CLK_DIV);
   localparam logic [PER_W-1:0] PER_LAST = PER_W'(FRAME_SCLKS - 1);
   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CLK_DIV - 1);

   seq_state_e       state;
   logic [GAP_W-1:0] gap_cnt;

   assign busy   = (state != SEQ_IDLE);
   assign run    = (state == SEQ_FRAME);
   assign accept = (state == SEQ_IDLE) && start;
   assign done   = run && fall_evt && (period == PER_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         cs_n    <= 1'b1;
         period  <= '0;
         gap_cnt <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state  <= SEQ_FRAME;
                  cs_n   <= 1'b0;
                  period <= '0;
               end
            end
            SEQ_FRAME: begin
               if (fall_evt) begin
                  if (period == PER_LAST) begin
                     state   <= SEQ_GAP;
                     cs_n    <= 1'b1;
                     gap_cnt <= '0;
                  end else begin
                     period <= period + 1'b1;
                  end
               end
            end
            SEQ_GAP: begin
               if (gap_cnt == GAP_LAST) state <= SEQ_IDLE;
               else                     gap_cnt <= gap_cnt + 1'b1;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   // checker-side count of chip-select high time, saturating
   logic [GAP_W:0] cs_hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cs_hi_cnt <= (GAP_W+1)'(CLK_DIV);
      else if (!cs_n)                      cs_hi_cnt <= '0;
      else if (cs_hi_cnt < (GAP_W+1)'(CLK_DIV)) cs_hi_cnt <= cs_hi_cnt + 1'b1;
   end

   AST_CS_FALL_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !$past(busy)); // R8
   AST_CS_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (cs_hi_cnt >= (GAP_W+1)'(CLK_DIV))); // R9
   AST_BUSY_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy); // R8

endmodule

// File: rtl/adcf_shift.sv
module adcf_shift #(
   parameter int unsigned CTRL_W      = 8,
   parameter int unsigned RES_W       = 12,
   parameter int unsigned FRAME_SCLKS = 24,
   parameter int unsigned DOUT_SYNC   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              done,
   input  logic [adcf_pkg::width_of(FRAME_SCLKS)-1:0] period,
   input  logic              dout,
   output logic              din,
   output logic [RES_W-1:0]  result,
   output logic              result_valid
);
   localparam int unsigned PER_W     = adcf_pkg::width_of(FRAME_SCLKS);
   localparam int unsigned RES_FIRST = CTRL_W + 1;
   localparam int unsigned RES_LAST  = RES_FIRST + RES_W - 1;
   localparam logic [PER_W-1:0] WIN_LO = PER_W'(RES_FIRST);
   localparam logic [PER_W-1:0] WIN_HI = PER_W'(RES_LAST);

   logic dout_s;

   generate
      if (DOUT_SYNC == 0) begin : g_dout_direct
         assign dout_s = dout;
      end else if (DOUT_SYNC == 1) begin : g_dout_flop
         logic dout_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout_q <= 1'b0;
            else        dout_q <= dout;
         end
         assign dout_s = dout_q;
      end else begin : g_bad_sync
         $error("adcf_shift: DOUT_SYNC must be 0 or 1");
      end
   endgenerate

   logic [CTRL_W-1:0] tx_q;
   logic [RES_W-1:0]  rx_q;
   logic              done_q;
   logic              in_window;

   assign in_window = (period >= WIN_LO) && (period <= WIN_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         din  <= 1'b0;
      end else if (accept) begin
         din  <= ctrl[CTRL_W-1];
         tx_q <= {ctrl[CTRL_W-2:0], 1'b0};
      end else if (fall_evt) begin
         din  <= tx_q[CTRL_W-1];
         tx_q <= {tx_q[CTRL_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q         <= '0;
         result       <= '0;
         done_q       <= 1'b0;
         result_valid <= 1'b0;
      end else begin
         if (rise_evt && in_window) rx_q <= {rx_q[RES_W-2:0], dout_s};
         if (done) result <= rx_q;
         done_q       <= done;
         result_valid <= done_q;
      end
   end

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid); // R7
   AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $past(done, 2)); // R7

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
   parameter int unsigned CLK_DIV     = 4,
   parameter int unsigned CHAN_W      = 3,
   parameter int unsigned RES_W       = 12,
   parameter int unsigned FRAME_SCLKS = 24,
   parameter int unsigned DOUT_SYNC   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CHAN_W-1:0] chan,
   input  logic              bipolar,
   input  logic              differential,
   input  logic              pwr_down,
   output logic              busy,
   output logic              cs_n,
   output logic              sclk,
   output logic              din,
   input  logic              dout,
   output logic [RES_W-1:0]  result,
   output logic              result_valid
);
   localparam int unsigned CTRL_W = CHAN_W + 5;
   localparam int unsigned PER_W  = adcf_pkg::width_of(FRAME_SCLKS);

   generate
      if (CHAN_W < 1) begin : g_bad_chan
         $error("adc_frame_ctrl: CHAN_W must be at least 1");
      end
      if (RES_W < 2) begin : g_bad_res
         $error("adc_frame_ctrl: RES_W must be at least 2");
      end
      if (FRAME_SCLKS < CTRL_W + 1 + RES_W) begin : g_bad_frame
         $error("adc_frame_ctrl: FRAME_SCLKS too short for command and result");
      end
      if (DOUT_SYNC == 1 && CLK_DIV < 4) begin : g_bad_sync_div
         $error("adc_frame_ctrl: a synchronised dout needs CLK_DIV of 4 or more");
      end
   endgenerate

   // command word: start marker, channel, unipolar, single-ended, external clock, power-down
   logic [CTRL_W-1:0] ctrl_word;
   assign ctrl_word = {1'b1, chan, ~bipolar, ~differential, 1'b1, pwr_down};

   logic             run, accept, done, rise_evt, fall_evt;
   logic [PER_W-1:0] period;

   adcf_seq #(
      .CLK_DIV     (CLK_DIV),
      .FRAME_SCLKS (FRAME_SCLKS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .fall_evt (fall_evt),
      .busy     (busy),
      .run      (run),
      .cs_n     (cs_n),
      .accept   (accept),
      .done     (done),
      .period   (period)
   );

   adcf_sclk_gen #(
      .CLK_DIV (CLK_DIV)
   ) u_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sclk     (sclk),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   adcf_shift #(
      .CTRL_W      (CTRL_W),
      .RES_W       (RES_W),
      .FRAME_SCLKS (FRAME_SCLKS),
      .DOUT_SYNC   (DOUT_SYNC)
   ) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept       (accept),
      .ctrl         (ctrl_word),
      .rise_evt     (rise_evt),
      .fall_evt     (fall_evt),
      .done         (done),
      .period       (period),
      .dout         (dout),
      .din          (din),
      .result       (result),
      .result_valid (result_valid)
   );

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk); // R3
   AST_DIN_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !din); // R4
   AST_DIN_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(din)); // R4
   AST_VALID_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (cs_n && !sclk)); // R7
   AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> $stable(result)); // R7

endmodule

// File: tb/adc_frame_ctrl_bench.sv
module adc_frame_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int FRAME      = 24;
   localparam int CS_END     = FRAME * DIV;
   localparam int IDLE_K     = CS_END + DIV;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  chan = 3'd0;
   logic        bipolar = 1'b0, differential = 1'b0, pwr_down = 1'b0;
   logic        busy, cs_n, sclk, din, result_valid;
   logic        dout = 1'b0;
   logic [11:0] result;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_frame_ctrl #(.CLK_DIV(DIV)) u_adc_frame_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .chan(chan),
      .bipolar(bipolar), .differential(differential), .pwr_down(pwr_down),
      .busy(busy), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
      .result(result), .result_valid(result_valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural converter model ----------------
   logic [11:0] conv_code = 12'h000;
   logic        conv_pad  = 1'b0;
   int          rcnt = 0, fcnt = 0;
   logic [7:0]  rx_byte = 8'h00;
   logic [7:0]  last_ctrl = 8'h00;

   always @(negedge cs_n) begin
      rcnt = 0; fcnt = 0; dout = conv_pad;
   end
   always @(posedge cs_n) begin
      if (rst_n) check(rcnt == FRAME, "R3 rising edges per frame", rcnt, FRAME);
      dout = 1'b0;
   end
   always @(posedge sclk) begin
      if (!cs_n) begin
         rcnt++;
         if (rcnt <= 8) rx_byte = {rx_byte[6:0], din};
         if (rcnt == 8) last_ctrl = rx_byte;
      end
   end
   always @(negedge sclk) begin
      if (!cs_n) begin
         fcnt++;
         if (fcnt >= 9 && fcnt <= 20) dout = conv_code[20 - fcnt];
         else                         dout = conv_pad;
      end
   end

   // ---------------- cycle timing reference model ----------------
   int k = IDLE_K;
   always @(posedge clk) begin
      if (!rst_n)          k <= IDLE_K;
      else if (k >= IDLE_K) begin
         if (start) k <= 0;
      end else             k <= k + 1;
   end
   always @(negedge clk) begin
      if (rst_n) begin
         check(cs_n == !(k < CS_END), "R7 cs_n timing", int'(cs_n), int'(!(k < CS_END)));
         check(busy == (k < IDLE_K), "R8 busy timing", int'(busy), int'(k < IDLE_K));
         check(result_valid == (k == CS_END + 1), "R7 valid timing",
               int'(result_valid), int'(k == CS_END + 1));
         check(sclk == ((k < CS_END) && ((k % DIV) >= DIV/2)), "R3 sclk shape",
               int'(sclk), int'((k < CS_END) && ((k % DIV) >= DIV/2)));
         if (cs_n) check(din == 1'b0, "R4 din idle", int'(din), 0);
      end
   end

   function automatic logic [7:0] exp_ctrl(input logic [2:0] c, input logic b,
                                            input logic d, input logic p);
      return {1'b1, c, ~b, ~d, 1'b1, p};
   endfunction

   task automatic wait_valid(output bit got);
      got = 0;
      for (int i = 0; i < 400 && !got; i++) begin
         @(negedge clk);
         if (result_valid) got = 1;
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400 && busy; i++) @(negedge clk);
   endtask

   task automatic run_frame(input logic [2:0] c, input logic b, input logic d,
                            input logic p, input logic [11:0] code, input logic pad);
      bit got;
      conv_code = code; conv_pad = pad;
      @(negedge clk);
      chan = c; bipolar = b; differential = d; pwr_down = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_valid(got);
      check(got, "R7 valid seen", int'(got), 1);
      check(result == code, pad ? "R6 padding ignored" : "R5 result", int'(result), int'(code));
      check(last_ctrl == exp_ctrl(c, b, d, p), "R2 command word",
            int'(last_ctrl), int'(exp_ctrl(c, b, d, p)));
      wait_idle();
      check(result == code, "R7 result held", int'(result), int'(code));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n == 1'b1 && sclk == 1'b0 && din == 1'b0, "R1 reset pins",
            int'({cs_n, sclk, din}), 4);
      check(busy == 1'b0 && result_valid == 1'b0 && result == 12'h000, "R1 reset status",
            int'({busy, result_valid, result}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_frame(3'd0, 1'b0, 1'b0, 1'b0, 12'hA5C, 1'b0);
      run_frame(3'd5, 1'b1, 1'b0, 1'b1, 12'h3E1, 1'b1);
      run_frame(3'd7, 1'b0, 1'b1, 1'b0, 12'hFFF, 1'b0);
      run_frame(3'd2, 1'b1, 1'b1, 1'b1, 12'h000, 1'b1);
      run_frame(3'd1, 1'b0, 1'b0, 1'b1, 12'h800, 1'b1);
      run_frame(3'd6, 1'b1, 1'b0, 1'b0, 12'h001, 1'b0);

      // R8: a start during a frame is dropped
      begin
         bit got;
         conv_code = 12'h5A5; conv_pad = 1'b0;
         @(negedge clk);
         chan = 3'd3; bipolar = 1'b0; differential = 1'b0; pwr_down = 1'b0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (30) @(negedge clk);
         chan = 3'd4; bipolar = 1'b1; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait_valid(got);
         check(last_ctrl == exp_ctrl(3'd3, 1'b0, 1'b0, 1'b0), "R8 busy start ignored",
               int'(last_ctrl), int'(exp_ctrl(3'd3, 1'b0, 1'b0, 1'b0)));
         wait_idle();
         repeat (10) @(negedge clk);
         check(cs_n == 1'b1, "R8 no extra frame", int'(cs_n), 1);
      end

      // R9: start held high gives back-to-back frames with a chip-select gap
      begin
         bit got;
         conv_code = 12'h6C3; conv_pad = 1'b1;
         @(negedge clk);
         chan = 3'd4; bipolar = 1'b1; differential = 1'b1; pwr_down = 1'b1; start = 1'b1;
         wait_valid(got);
         check(result == 12'h6C3, "R9 first of pair", int'(result), 12'h6C3);
         conv_code = 12'h1F0;
         wait_valid(got);
         start = 1'b0;
         check(got && result == 12'h1F0, "R9 second of pair", int'(result), 12'h1F0);
         check(last_ctrl == exp_ctrl(3'd4, 1'b1, 1'b1, 1'b1), "R2 command word pair",
               int'(last_ctrl), int'(exp_ctrl(3'd4, 1'b1, 1'b1, 1'b1)));
         wait_idle();
      end

      repeat (5) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule